// File: doc/BRIEF.md
# Two-Way Hashed Host Route Slot Locator

This engine finds where a host route lives, or could live, in a route memory that is split into two hashed sub-tables. A caller presents a 32-bit IPv4 destination key, the route kind, a mode bit and the table control word, then pulses start. The engine hashes the key once for each sub-table, using the hash variant that the control word selects for that sub-table. It then reads the candidate slots of the addressed bucket one at a time through a synchronous read port with one cycle of latency.

Each bucket spans eight physical positions, and only the first six of them hold entries. The engine reports its result as a packed logical index that skips the two unused positions of every bucket. In free-slot mode it returns the first empty slot. In match mode it returns the first IPv4 unicast entry whose stored address equals the key. If no probed slot qualifies, it raises done with the found flag low.

Top module: `host_slot_finder`

## Requirements
- R1: After a synchronous active-high reset, done_o, found_o, busy_o and mem_rd_en_o are all low.
- R2: Hash variant 0 XORs four fields of the key: bits [31:27] zero-extended to 9 bits, bits [26:18], bits [17:9] and bits [8:0].
- R3: Hash variant 1 adds fields [31:27], [26:18] and [17:9]. It folds the sum twice, each time by adding bits [17:9] into bits [8:0] and keeping 9 bits. The folded value is then XORed with key bits [8:0].
- R4: Control bit 2 selects the hash variant of sub-table 0 and control bit 3 selects that of sub-table 1. Both bits are captured when start is accepted. All other control bits have no effect.
- R5: Each probe reads the physical address {table, hash[8:0], slot}, with the table bit at position 12. Every slot of sub-table 0 is probed before any slot of sub-table 1.
- R6: For kinds 0 (IPv4 unicast) and 2 (IPv6 unicast) the slot steps by 1 through 0..5. For kinds 1 and 3 it steps by 3 through 0 and 3. Slots 6 and 7 are never read.
- R7: In free-slot mode (match_mode_i = 0), the first probed entry whose word-0 bit 31 (valid) is clear is the result.
- R8: In match mode, the first probed entry is the result if its valid bit is set, its word-0 bits [30:29] equal 0, and its word 4 equals the key. Entries of any other kind never match.
- R9: When found_o is high, index_o equals (phys / 8) * 6 + (phys % 8) for the physical address of the winning probe.
- R10: When every probe of both sub-tables fails, done_o is raised with found_o low.
- R11: mem_rd_en_o is high for one cycle per probe, and the entry returned on the next cycle is judged then. For a search of n probes, done_o pulses for one cycle 2n+1 cycles after the cycle in which start is driven.
- R12: A start pulse that arrives while busy_o is high is ignored, and the search in progress finishes with its own key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search; accepted only when idle |
| key_i | input | 32 | IPv4 destination key |
| kind_i | input | 2 | Route kind: 0 v4 unicast, 1 v4 multicast, 2 v6 unicast, 3 v6 multicast |
| match_mode_i | input | 1 | 0 = find a free slot, 1 = find the matching entry |
| tbl_ctrl_i | input | 32 | Table control word; bits 2 and 3 pick the hash variants |
| mem_rd_en_o | output | 1 | Read strobe to the route memory |
| mem_rd_addr_o | output | 13 | Physical address of the probe |
| mem_word0_i | input | 32 | Word 0 of the entry read on the previous cycle |
| mem_word4_i | input | 32 | Word 4 (IPv4 address) of the entry read on the previous cycle |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| found_o | output | 1 | Valid with done_o: a qualifying slot was found |
| index_o | output | 13 | Logical index of the last slot found |

## Verification
Two events can land in the same evaluation cycle. A hit on the last slot of sub-table 0 coincides with the move to sub-table 1, and a hit on the last slot of sub-table 1 coincides with the not-found decision. The bench sets these up by placing a qualifying entry at slot 5 (or slot 3 for the stride-3 kinds) and a second candidate at slot 0 of sub-table 1. It also places decoys in slots 6 and 7. The outcome is judged against a reference walk of the probe list, which requires the earlier hit to win and the probe list to stop there. Separately, a second start is pulsed mid-search, and the bench checks that neither the probe list nor the result moves.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    localparam int KEY_W      = 32;
    localparam int HASH_W     = 9;
    localparam int SLOT_W     = 3;
    localparam int SLOTS_USED = 6;
    localparam int TABLES     = 2;
    localparam int TBL_W      = $clog2(TABLES);
    localparam int PHYS_W     = TBL_W + HASH_W + SLOT_W;
    localparam int LIDX_W     = PHYS_W;
    localparam int CTRL_W     = 32;
    localparam int ALG_BASE   = 2;
    localparam int VALID_BIT  = 31;
    localparam int KIND_LO    = 29;

    typedef enum logic [1:0] {
        RK_V4_UC = 2'd0,
        RK_V4_MC = 2'd1,
        RK_V6_UC = 2'd2,
        RK_V6_MC = 2'd3
    } route_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_READ = 2'd1,
        SQ_EVAL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [KEY_W-1:0]  key;
        route_kind_e       kind;
        logic              want_match;
        logic [TABLES-1:0] alg;
    } lookup_req_t;

    function automatic logic [SLOT_W-1:0] slot_step(route_kind_e k);
        return (k == RK_V4_UC || k == RK_V6_UC) ? SLOT_W'(1) : SLOT_W'(3);
    endfunction

    function automatic logic [PHYS_W-1:0] logical_to_phys(logic [LIDX_W-1:0] l);
        int unsigned v;
        v = (int'(l) / SLOTS_USED) * (1 << SLOT_W) + (int'(l) % SLOTS_USED);
        return PHYS_W'(v);
    endfunction

endpackage

// File: rtl/hs_hash.sv
module hs_hash
    import hsf_pkg::*;
#(
    parameter int KW = KEY_W,
    parameter int HW = HASH_W
) (
    input  logic [KW-1:0] key,
    input  logic          alg,
    output logic [HW-1:0] hash
);
    localparam int TOP_W = KW - 3*HW;
    localparam int SUM_W = HW + 2;

    logic [HW-1:0]    row0, row1, row2, row3;
    logic [HW-1:0]    xor_h, fold_h;
    logic [SUM_W-1:0] sum0;
    logic [HW:0]      sum1;
    logic [HW-1:0]    sum2;

    always_comb begin
        row0 = HW'(key[KW-1 -: TOP_W]);
        row1 = key[3*HW-1 -: HW];
        row2 = key[2*HW-1 -: HW];
        row3 = key[HW-1:0];
        xor_h = row0 ^ row1 ^ row2 ^ row3;
        sum0 = SUM_W'(row0) + SUM_W'(row1) + SUM_W'(row2);
        sum1 = (HW+1)'(sum0[HW-1:0]) + (HW+1)'(sum0[SUM_W-1:HW]);
        sum2 = sum1[HW-1:0] + HW'(sum1[HW]);
        fold_h = sum2 ^ row3;
        hash = alg ? fold_h : xor_h;
    end
endmodule

// File: rtl/hs_index_map.sv
module hs_index_map
    import hsf_pkg::*;
#(
    parameter int PW = PHYS_W,
    parameter int SW = SLOT_W,
    parameter int SU = SLOTS_USED,
    parameter int LW = LIDX_W
) (
    input  logic [PW-1:0] phys,
    output logic [LW-1:0] logical
);
    always_comb begin
        logical = LW'(phys[PW-1:SW]) * LW'(SU) + LW'(phys[SW-1:0]);
    end
endmodule

// File: rtl/hs_probe_seq.sv
module hs_probe_seq
    import hsf_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int SU = SLOTS_USED,
    parameter int NT = TABLES,
    parameter int TW = TBL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [SW-1:0] step,
    input  logic          hit,
    output logic          busy,
    output logic          rd_en,
    output logic [TW-1:0] tbl,
    output logic [SW-1:0] slot,
    output logic          take_hit,
    output logic          done,
    output logic          found
);
    seq_state_e    state;
    logic [TW-1:0] tbl_q;
    logic [SW-1:0] slot_q;
    logic          slot_last, tbl_last;

    always_comb begin
        slot_last = ((SW+1)'(slot_q) + (SW+1)'(step)) >= (SW+1)'(SU);
        tbl_last  = (tbl_q == TW'(NT-1));
        busy      = (state != SQ_IDLE);
        rd_en     = (state == SQ_READ);
        take_hit  = (state == SQ_EVAL) && hit;
        tbl       = tbl_q;
        slot      = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            tbl_q  <= '0;
            slot_q <= '0;
            done   <= 1'b0;
            found  <= 1'b0;
        end else begin
            done  <= 1'b0;
            found <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    tbl_q  <= '0;
                    slot_q <= '0;
                    state  <= SQ_READ;
                end
                SQ_READ: state <= SQ_EVAL;
                SQ_EVAL: begin
                    if (hit) begin
                        done  <= 1'b1;
                        found <= 1'b1;
                        state <= SQ_IDLE;
                    end else if (slot_last && tbl_last) begin
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end else if (slot_last) begin
                        tbl_q  <= tbl_q + TW'(1);
                        slot_q <= '0;
                        state  <= SQ_READ;
                    end else begin
                        slot_q <= slot_q + step;
                        state  <= SQ_READ;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R6: the unused bucket positions are never addressed
    p_slot_bound_r6: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(slot) < SU));

    // R11: one read strobe per probe, followed by an evaluation cycle
    p_rd_single_r11: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: sub-table order never goes backwards within a search
    p_table_order_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (tbl >= $past(tbl)));

    // R10: found is only reported together with done
    p_found_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        found |-> done);
endmodule

// File: rtl/host_slot_finder.sv
module host_slot_finder
    import hsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [1:0]        kind_i,
    input  logic              match_mode_i,
    input  logic [CTRL_W-1:0] tbl_ctrl_i,
    output logic              mem_rd_en_o,
    output logic [PHYS_W-1:0] mem_rd_addr_o,
    input  logic [31:0]       mem_word0_i,
    input  logic [31:0]       mem_word4_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              found_o,
    output logic [LIDX_W-1:0] index_o
);
    lookup_req_t       req_q;
    logic              busy, take_hit, entry_hit;
    logic [TBL_W-1:0]  tbl;
    logic [SLOT_W-1:0] slot;
    logic [HASH_W-1:0] hash_arr [TABLES];
    logic [PHYS_W-1:0] phys;
    logic [LIDX_W-1:0] logical, index_q;
    logic              unused_bits;

    assign unused_bits = ^{tbl_ctrl_i, mem_word0_i[KIND_LO-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (start_i && !busy) begin
            req_q.key        <= key_i;
            req_q.kind       <= route_kind_e'(kind_i);
            req_q.want_match <= match_mode_i;
            for (int t = 0; t < TABLES; t++) begin
                req_q.alg[t] <= tbl_ctrl_i[ALG_BASE + t];
            end
        end
    end

    for (genvar g = 0; g < TABLES; g++) begin : g_hash
        hs_hash #(.KW(KEY_W), .HW(HASH_W)) u_hash (
            .key  (req_q.key),
            .alg  (req_q.alg[g]),
            .hash (hash_arr[g])
        );
    end

    always_comb begin
        phys = {tbl, hash_arr[tbl], slot};
        if (req_q.want_match) begin
            entry_hit = mem_word0_i[VALID_BIT]
                     && (mem_word0_i[KIND_LO+1:KIND_LO] == RK_V4_UC)
                     && (mem_word4_i == req_q.key);
        end else begin
            entry_hit = !mem_word0_i[VALID_BIT];
        end
    end

    hs_probe_seq #(.SW(SLOT_W), .SU(SLOTS_USED), .NT(TABLES), .TW(TBL_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .step     (slot_step(req_q.kind)),
        .hit      (entry_hit),
        .busy     (busy),
        .rd_en    (mem_rd_en_o),
        .tbl      (tbl),
        .slot     (slot),
        .take_hit (take_hit),
        .done     (done_o),
        .found    (found_o)
    );

    hs_index_map #(.PW(PHYS_W), .SW(SLOT_W), .SU(SLOTS_USED), .LW(LIDX_W)) u_map (
        .phys    (phys),
        .logical (logical)
    );

    always_ff @(posedge clk) begin
        if (rst)           index_q <= '0;
        else if (take_hit) index_q <= logical;
    end

    assign index_o       = index_q;
    assign busy_o        = busy;
    assign mem_rd_addr_o = phys;

    // R9: reported index maps back to the winning probe address
    p_index_roundtrip_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && found_o) |-> (logical_to_phys(index_o) == $past(phys)));

    // R12: request held while a search runs, whatever start does
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> $stable(req_q));
endmodule

// File: tb/host_slot_finder_bench.sv
module host_slot_finder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] key_i = '0;
    logic [1:0]  kind_i = '0;
    logic        match_mode_i = 1'b0;
    logic [31:0] tbl_ctrl_i = '0;
    logic        mem_rd_en_o;
    logic [12:0] mem_rd_addr_o;
    logic [31:0] mem_word0_i = '0;
    logic [31:0] mem_word4_i = '0;
    logic        busy_o, done_o, found_o;
    logic [12:0] index_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_slot_finder u_host_slot_finder (
        .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i), .kind_i(kind_i),
        .match_mode_i(match_mode_i), .tbl_ctrl_i(tbl_ctrl_i),
        .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_word0_i(mem_word0_i), .mem_word4_i(mem_word4_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .index_o(index_o)
    );

    logic [31:0] mem0 [int];
    logic [31:0] mem4 [int];
    int          seen_q[$];
    int          exp_q[$];
    bit          exp_found;
    int          exp_idx;
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;

    always @(posedge clk) begin
        if (mem_rd_en_o) begin
            mem_word0_i <= mem0.exists(int'(mem_rd_addr_o)) ? mem0[int'(mem_rd_addr_o)] : 32'h0;
            mem_word4_i <= mem4.exists(int'(mem_rd_addr_o)) ? mem4[int'(mem_rd_addr_o)] : 32'h0;
        end
    end

    always @(negedge clk) if (mem_rd_en_o) seen_q.push_back(int'(mem_rd_addr_o));

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R2 / R3 reference hash
    function automatic int ref_hash(logic [31:0] ip, bit alg);
        int r0, r1, r2, r3, s0, s1, ph;
        r0 = int'(ip >> 27);
        r1 = int'((ip >> 18) & 32'h1ff);
        r2 = int'((ip >> 9) & 32'h1ff);
        r3 = int'(ip & 32'h1ff);
        if (!alg) return (r0 ^ r1 ^ r2 ^ r3) & 511;
        s0 = r0 + r1 + r2;
        s1 = (s0 & 511) + ((s0 >> 9) & 511);
        ph = (s1 & 511) + ((s1 >> 9) & 511);
        return (ph ^ r3) & 511;
    endfunction

    function automatic int phys_of(int t, logic [31:0] ip, logic [31:0] ctrl, int s);
        return (t << 12) | (ref_hash(ip, ctrl[2+t]) << 3) | s;
    endfunction

    task automatic ref_search(input logic [31:0] ip, input logic [1:0] kind,
                              input bit mm, input logic [31:0] ctrl);
        int stride, a;
        logic [31:0] w0, w4;
        bit hit;
        exp_q.delete();
        exp_found = 0;
        exp_idx = 0;
        stride = (kind == 2'd0 || kind == 2'd2) ? 1 : 3;
        for (int t = 0; t < 2; t++) begin
            for (int s = 0; s < 6; s += stride) begin
                a = phys_of(t, ip, ctrl, s);
                exp_q.push_back(a);
                w0 = mem0.exists(a) ? mem0[a] : 32'h0;
                w4 = mem4.exists(a) ? mem4[a] : 32'h0;
                hit = mm ? (w0[31] && w0[30:29] == 2'd0 && w4 == ip) : !w0[31];
                if (hit) begin
                    exp_found = 1;
                    exp_idx = (a / 8) * 6 + (a % 8);
                    return;
                end
            end
        end
    endtask

    task automatic put(input int a, input bit v, input logic [1:0] k, input logic [31:0] w4);
        mem0[a] = {v, k, 29'($urandom)};
        mem4[a] = w4;
    endtask

    task automatic run_case(input logic [31:0] ip, input logic [1:0] kind, input bit mm,
                            input logic [31:0] ctrl, input bit disturb, input string tag);
        int cnt;
        bit got_done, got_found, list_ok;
        int got_idx;
        ref_search(ip, kind, mm, ctrl);
        seen_q.delete();
        @(negedge clk);
        start_i = 1'b1; key_i = ip; kind_i = kind; match_mode_i = mm; tbl_ctrl_i = ctrl;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) start_i = 1'b0;
            if (disturb && cnt == 3) begin
                start_i = 1'b1; key_i = ~ip; kind_i = ~kind; match_mode_i = ~mm;
                tbl_ctrl_i = ~ctrl;
            end
            if (disturb && cnt == 4) start_i = 1'b0;
        end while (!done_o && cnt < 300);
        got_done = done_o;
        got_found = found_o;
        got_idx = int'(index_o);
        repeat (4) @(negedge clk);
        chk(got_done, tag, "R10 done raised", got_done, 1);
        chk(cnt == 2 * exp_q.size() + 1, tag, "R11 latency", cnt, 2 * exp_q.size() + 1);
        chk(seen_q.size() == exp_q.size(), tag, "R6 probe count", seen_q.size(), exp_q.size());
        list_ok = (seen_q.size() == exp_q.size());
        for (int i = 0; i < exp_q.size() && i < seen_q.size(); i++) begin
            if (seen_q[i] != exp_q[i]) begin
                list_ok = 0;
                $display("  probe %0d: actual=%0d expected=%0d", i, seen_q[i], exp_q[i]);
            end
        end
        chk(list_ok, tag, "R5 probe addresses (R2 R3 R4 hashes)",
            seen_q.size() > 0 ? seen_q[0] : -1, exp_q.size() > 0 ? exp_q[0] : -1);
        chk(got_found == exp_found, tag, "R7 R8 found flag", got_found, exp_found);
        if (exp_found) chk(got_idx == exp_idx, tag, "R9 logical index", got_idx, exp_idx);
    endtask

    task automatic fill_random(input logic [31:0] ip, input logic [31:0] ctrl);
        for (int t = 0; t < 2; t++) begin
            for (int s = 0; s < 8; s++) begin
                bit v;
                logic [1:0] k;
                logic [31:0] w4;
                v = ($urandom % 10) < 8;
                k = ($urandom % 2 == 0) ? 2'd0 : 2'($urandom);
                w4 = ($urandom % 4 == 0) ? ip : $urandom;
                put(phys_of(t, ip, ctrl, s), v, k, w4);
            end
        end
    endtask

    initial begin
        logic [31:0] ip, ctrl;
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done_o == 0 && found_o == 0 && busy_o == 0 && mem_rd_en_o == 0,
            "R1", "reset outputs", {done_o, found_o, busy_o, mem_rd_en_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done_o == 0 && busy_o == 0 && mem_rd_en_o == 0, "R1", "idle after reset",
            {done_o, busy_o, mem_rd_en_o}, 0);

        // R7: empty memory, free mode, variant 0 both tables
        mem0.delete(); mem4.delete();
        run_case(32'hC0A8_0101, 2'd0, 1'b0, 32'h0, 1'b0, "R7");

        // R4 / R3: sub-table 0 full, variant 1 on sub-table 1 only, free slot at 2
        ip = 32'h0A01_02FE; ctrl = 32'h0000_0008;
        mem0.delete(); mem4.delete();
        for (int s = 0; s < 6; s++) put(phys_of(0, ip, ctrl, s), 1'b1, 2'd0, ~ip);
        put(phys_of(1, ip, ctrl, 0), 1'b1, 2'd0, ~ip);
        put(phys_of(1, ip, ctrl, 1), 1'b1, 2'd1, ~ip);
        run_case(ip, 2'd0, 1'b0, ctrl, 1'b0, "R4");

        // R10: every slot valid and no match in match mode; R12 disturb mid-search
        ip = 32'hFFFF_FFFF; ctrl = 32'hFFFF_FFF3;
        mem0.delete(); mem4.delete();
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 8; s++) put(phys_of(t, ip, ctrl, s), 1'b1, 2'd0, ip ^ 32'h1);
        run_case(ip, 2'd0, 1'b1, ctrl, 1'b0, "R10");
        run_case(ip, 2'd0, 1'b1, ctrl, 1'b1, "R12");

        // R6: stride 3 kind, match at slot 3 of sub-table 1, decoys at skipped slots
        ip = 32'h1234_5678; ctrl = 32'h0000_000C;
        mem0.delete(); mem4.delete();
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 8; s++) put(phys_of(t, ip, ctrl, s), 1'b1, 2'd0, ~ip);
        for (int s = 1; s < 8; s++) if (s != 3) put(phys_of(1, ip, ctrl, s), 1'b1, 2'd0, ip);
        put(phys_of(1, ip, ctrl, 3), 1'b1, 2'd0, ip);
        run_case(ip, 2'd1, 1'b1, ctrl, 1'b0, "R6");

        // R8: hit at last slot of sub-table 0 while sub-table 1 also holds the key
        ip = 32'h8000_01FF; ctrl = 32'h0000_0004;
        mem0.delete(); mem4.delete();
        for (int s = 0; s < 5; s++) put(phys_of(0, ip, ctrl, s), 1'b1, 2'd2, ip);
        put(phys_of(0, ip, ctrl, 5), 1'b1, 2'd0, ip);
        put(phys_of(0, ip, ctrl, 6), 1'b1, 2'd0, ip);
        put(phys_of(1, ip, ctrl, 0), 1'b1, 2'd0, ip);
        run_case(ip, 2'd2, 1'b1, ctrl, 1'b0, "R8");

        // R9: last slot of sub-table 1 free in free mode, stride 1
        ip = 32'h7FFF_FE00; ctrl = 32'h0000_000C;
        mem0.delete(); mem4.delete();
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 5 + (1 - t); s++) put(phys_of(t, ip, ctrl, s), 1'b1, 2'd3, ip);
        run_case(ip, 2'd0, 1'b0, ctrl, 1'b0, "R9");

        // R2 R3 R4: constrained random mix
        for (int n = 0; n < 40; n++) begin
            logic [1:0] k;
            bit mm;
            ip = $urandom; ctrl = $urandom;
            k = 2'($urandom); mm = 1'($urandom);
            mem0.delete(); mem4.delete();
            if ($urandom % 5 != 0) fill_random(ip, ctrl);
            run_case(ip, k, mm, ctrl, 1'b0, (n % 2 == 0) ? "R2" : "R3");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule